// File: doc/BRIEF.md
# Phase Current Waveform Capture

This block takes the three per-phase current sample streams of a metering datapath and picks one of them for inspection. A mode input chooses the source, the phase and an output rate. The block keeps one qualifying sample out of every 1, 2, 4 or 8 and latches it into a waveform holding register. Software or a serial transport reads that register. A sticky ready flag marks each new sample. An active-low interrupt line can report the flag to a host.

The block only observes the sample streams. It has no ready or stall signal back toward the producer, so the energy computation that consumes the same streams runs on unchanged. Sample words pass through bit-exact as 24-bit two's complement values.

Top module: `wave_capture_top`

## Requirements
- R1: While `rstN` is low and after its release, `waveData` is 0, `sampleReady` is 0 and `irqN` is 1, until the first capture.
- R2: A sample is captured only when `modeSrc` equals 3'b000. With any other source code, a valid sample leaves `waveData` and `sampleReady` unchanged and does not advance the decimation counter.
- R3: `modePhase` picks the captured lane: 2'b00 gives `sampA`, 2'b01 gives `sampB` and 2'b10 gives `sampC`. The reserved code 2'b11 behaves as 2'b00.
- R4: `modeRate` codes 0, 1, 2 and 3 keep one valid sample out of 1, 2, 4 and 8. The first valid sample after reset is kept, and so is the first one after a mode change. The skipped samples are discarded.
- R5: Any change of `modePhase` or `modeRate` restarts the decimation count, so the next valid sample is kept.
- R6: A capture sets `sampleReady` from the next clock edge onward. The flag stays set until a cycle with `statusRead` high, which clears it. If a capture happens in the same cycle as the read, the flag stays set.
- R7: `irqN` is low exactly when `sampleReady` is 1 and `irqEnable` is 1. With `irqEnable` at 0 the line stays high even while the flag is set.
- R8: A capture made while the flag is still set overwrites `waveData` with the newer sample, and the flag stays set.
- R9: A captured word is copied unchanged, including the extreme codes 24'h800000 and 24'h7FFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | Strobe: all three lanes carry a new sample |
| sampA | input | 24 | Phase A current sample |
| sampB | input | 24 | Phase B current sample |
| sampC | input | 24 | Phase C current sample |
| modeSrc | input | 3 | Source code; 000 selects current samples |
| modePhase | input | 2 | Phase code (11 treated as 00) |
| modeRate | input | 2 | Decimation code: divide by 2^code |
| irqEnable | input | 1 | Interrupt mask bit; 1 lets the flag drive the line |
| statusRead | input | 1 | Reset-on-read strobe for the ready flag |
| waveData | output | 24 | Latched waveform sample |
| sampleReady | output | 1 | Sticky new-sample flag |
| irqN | output | 1 | Active-low interrupt request |

## Verification
The bound checker watches the flag and interrupt rules on every cycle. These are: the stickiness of the flag, clearing on a read, the masking of the interrupt line, and the holding of `waveData` across idle cycles and other-source cycles. The checker also requires that any change of data comes with a set flag. Which lane is chosen and which samples the decimator keeps depend on sequences of input values. Only the bench scenarios show these, by comparing against the bench's own model. The same holds for the restart after a mode change and for a capture that coincides with a read.

// File: rtl/wcap_pkg.sv
package wcap_pkg;
  localparam int SAMPLE_W = 24;
  localparam int PHASES   = 3;
  localparam int SRC_W    = 3;
  localparam int PHASE_W  = 2;
  localparam int RATE_W   = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic               loadEn;
    logic [PHASE_W-1:0] laneIdx;
  } ctrl2dp_t;
endpackage

// File: rtl/wcap_ctrl.sv
module wcap_ctrl #(
  parameter int SRC_W   = wcap_pkg::SRC_W,
  parameter int PHASE_W = wcap_pkg::PHASE_W,
  parameter int RATE_W  = wcap_pkg::RATE_W,
  parameter int PHASES  = wcap_pkg::PHASES
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sampleValid,
  input  logic [SRC_W-1:0]   modeSrc,
  input  logic [PHASE_W-1:0] modePhase,
  input  logic [RATE_W-1:0]  modeRate,
  input  logic               irqEnable,
  input  logic               statusRead,
  output wcap_pkg::ctrl2dp_t dpCtl,
  output logic               sampleReady,
  output logic               irqN
);
  // widest divide is 2^(2^RATE_W - 1); counter holds divide-1
  localparam int CNT_W = (1 << RATE_W) - 1;

  logic [PHASE_W-1:0] prevPhase;
  logic [RATE_W-1:0]  prevRate;
  logic [CNT_W-1:0]   skipCnt;
  logic [CNT_W-1:0]   effCnt;
  logic [CNT_W-1:0]   reloadVal;
  logic [CNT_W:0]     span;
  logic               modeChanged;
  logic               srcHit;
  logic               keepNow;
  logic               readyFlag;

  assign modeChanged = (modePhase != prevPhase) || (modeRate != prevRate);
  assign srcHit      = sampleValid && (modeSrc == '0);

  always_comb begin
    span      = {{CNT_W{1'b0}}, 1'b1} << modeRate;
    reloadVal = CNT_W'(span - 1'b1);
    effCnt    = modeChanged ? '0 : skipCnt;
    keepNow   = srcHit && (effCnt == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevPhase <= '0;
      prevRate  <= '0;
      skipCnt   <= '0;
    end else begin
      prevPhase <= modePhase;
      prevRate  <= modeRate;
      if (keepNow)     skipCnt <= reloadVal;
      else if (srcHit) skipCnt <= effCnt - 1'b1;
      else             skipCnt <= effCnt;
    end
  end

  // sticky flag: a new capture wins over a same-cycle read
  always_ff @(posedge clk) begin
    if (!rstN)           readyFlag <= 1'b0;
    else if (keepNow)    readyFlag <= 1'b1;
    else if (statusRead) readyFlag <= 1'b0;
  end

  always_comb begin
    dpCtl.loadEn  = keepNow;
    dpCtl.laneIdx = (int'(modePhase) >= PHASES) ? '0 : modePhase;
  end

  assign sampleReady = readyFlag;
  assign irqN        = ~(readyFlag & irqEnable);
endmodule

// File: rtl/wcap_dp.sv
module wcap_dp #(
  parameter int SAMPLE_W = wcap_pkg::SAMPLE_W,
  parameter int PHASES   = wcap_pkg::PHASES
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  wcap_pkg::ctrl2dp_t               dpCtl,
  input  logic [PHASES-1:0][SAMPLE_W-1:0]  lanes,
  output logic [SAMPLE_W-1:0]              waveData
);
  logic [SAMPLE_W-1:0] picked;
  logic [SAMPLE_W-1:0] holdReg;

  always_comb begin
    picked = lanes[0];
    for (int i = 1; i < PHASES; i++)
      if (int'(dpCtl.laneIdx) == i) picked = lanes[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN)             holdReg <= '0;
    else if (dpCtl.loadEn) holdReg <= picked;
  end

  assign waveData = holdReg;
endmodule

// File: rtl/wave_capture_top.sv
module wave_capture_top #(
  parameter int SAMPLE_W = wcap_pkg::SAMPLE_W,
  parameter int SRC_W    = wcap_pkg::SRC_W,
  parameter int PHASE_W  = wcap_pkg::PHASE_W,
  parameter int RATE_W   = wcap_pkg::RATE_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampA,
  input  logic [SAMPLE_W-1:0] sampB,
  input  logic [SAMPLE_W-1:0] sampC,
  input  logic [SRC_W-1:0]    modeSrc,
  input  logic [PHASE_W-1:0]  modePhase,
  input  logic [RATE_W-1:0]   modeRate,
  input  logic                irqEnable,
  input  logic                statusRead,
  output logic [SAMPLE_W-1:0] waveData,
  output logic                sampleReady,
  output logic                irqN
);
  localparam int LANES = 3;

  wcap_pkg::ctrl2dp_t              dpCtl;
  logic [LANES-1:0][SAMPLE_W-1:0]  lanes;

  assign lanes = {sampC, sampB, sampA};

  wcap_ctrl #(
    .SRC_W(SRC_W), .PHASE_W(PHASE_W), .RATE_W(RATE_W), .PHASES(LANES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .modeSrc(modeSrc), .modePhase(modePhase), .modeRate(modeRate),
    .irqEnable(irqEnable), .statusRead(statusRead),
    .dpCtl(dpCtl), .sampleReady(sampleReady), .irqN(irqN)
  );

  wcap_dp #(.SAMPLE_W(SAMPLE_W), .PHASES(LANES)) u_dp (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl), .lanes(lanes), .waveData(waveData)
  );
endmodule

// File: rtl/wcap_checker.sv
module wcap_checker #(
  parameter int SAMPLE_W = 24,
  parameter int SRC_W    = 3
) (
  input logic                clk,
  input logic                rstN,
  input logic                sampleValid,
  input logic [SRC_W-1:0]    modeSrc,
  input logic                irqEnable,
  input logic                statusRead,
  input logic [SAMPLE_W-1:0] waveData,
  input logic                sampleReady,
  input logic                irqN
);
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    !irqN |-> sampleReady); // R7
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    !irqEnable |-> irqN); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (sampleReady && !statusRead) |=> sampleReady); // R6
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (statusRead && !sampleValid) |=> !sampleReady); // R6
  AST_OTHER_SRC_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && modeSrc != '0) |=> $stable(waveData)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> $stable(waveData)); // R8
  AST_NEW_DATA_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(waveData) |-> sampleReady); // R6
endmodule

bind wave_capture_top wcap_checker #(.SAMPLE_W(SAMPLE_W), .SRC_W(SRC_W)) u_chk (
  .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .modeSrc(modeSrc),
  .irqEnable(irqEnable), .statusRead(statusRead), .waveData(waveData),
  .sampleReady(sampleReady), .irqN(irqN)
);

// File: tb/tb_wave_capture_top.sv
module tb_wave_capture_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleValid = 1'b0;
  logic [23:0] sampA = '0, sampB = '0, sampC = '0;
  logic [2:0]  modeSrc = '0;
  logic [1:0]  modePhase = '0;
  logic [1:0]  modeRate = '0;
  logic        irqEnable = 1'b0;
  logic        statusRead = 1'b0;
  logic [23:0] waveData;
  logic        sampleReady;
  logic        irqN;

  always #2.5 clk = ~clk;

  wave_capture_top dut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .sampA(sampA), .sampB(sampB), .sampC(sampC),
    .modeSrc(modeSrc), .modePhase(modePhase), .modeRate(modeRate),
    .irqEnable(irqEnable), .statusRead(statusRead),
    .waveData(waveData), .sampleReady(sampleReady), .irqN(irqN)
  );

  typedef struct {
    logic [23:0] d;
    logic        f;
    logic        irq;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int errors = 0;

  // reference model state
  int          mCnt = 0;
  logic        mFlag = 1'b0;
  logic [23:0] mData = '0;

  task automatic check(string tag, string what, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic pushExp(string tag);
    expItem_t it;
    it.d = mData; it.f = mFlag; it.irq = ~(mFlag & irqEnable); it.tag = tag;
    expQ.push_back(it);
  endtask

  // driver: one cycle, optional sample and optional status read
  task automatic drive(bit vld, bit rd, logic [23:0] a, logic [23:0] b,
                       logic [23:0] c, string tag);
    @(negedge clk);
    sampleValid = vld; statusRead = rd;
    sampA = a; sampB = b; sampC = c;
    if (rd) mFlag = 1'b0;
    if (vld && modeSrc == 3'b000) begin
      if (mCnt == 0) begin
        mData = (modePhase == 2'd1) ? b : (modePhase == 2'd2) ? c : a;
        mFlag = 1'b1;
        mCnt  = (1 << modeRate) - 1;
      end else mCnt--;
    end
    @(posedge clk); #1;
    sampleValid = 1'b0; statusRead = 1'b0;
    pushExp(tag);
  endtask

  task automatic setMode(logic [2:0] s, logic [1:0] p, logic [1:0] r);
    @(negedge clk);
    if (p != modePhase || r != modeRate) mCnt = 0;
    modeSrc = s; modePhase = p; modeRate = r;
    @(posedge clk); #1;
  endtask

  task automatic setIrq(bit en, string tag);
    @(negedge clk);
    irqEnable = en;
    @(posedge clk); #1;
    pushExp(tag);
  endtask

  // monitor: compares pending expectations away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      while (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        check(it.tag, "waveData", waveData, it.d);
        check(it.tag, "sampleReady", {23'd0, sampleReady}, {23'd0, it.f});
        check(it.tag, "irqN", {23'd0, irqN}, {23'd0, it.irq});
      end
    end
  end

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    // R1: outputs during reset
    @(negedge clk);
    check("R1", "waveData", waveData, 24'h0);
    check("R1", "sampleReady", {23'd0, sampleReady}, 24'd0);
    check("R1", "irqN", {23'd0, irqN}, 24'd1);
    rstN = 1'b1;
    @(posedge clk); #1;
    pushExp("R1");

    // R3/R4: phase A, divide by 1, every sample kept
    setIrq(1'b1, "R7");
    drive(1, 0, 24'h000011, 24'h000022, 24'h000033, "R3");
    drive(1, 0, 24'h000111, 24'h000222, 24'h000333, "R8");
    drive(1, 1, 24'h001111, 24'h002222, 24'h003333, "R6");
    drive(0, 1, 24'h0, 24'h0, 24'h0, "R6");
    // R3: phases B, C and reserved code; R9 extremes
    setMode(3'b000, 2'd1, 2'd0);
    drive(1, 0, 24'hABCDEF, 24'h800000, 24'h123456, "R9");
    setMode(3'b000, 2'd2, 2'd0);
    drive(1, 0, 24'hABCDEF, 24'h800000, 24'h7FFFFF, "R9");
    setMode(3'b000, 2'd3, 2'd0);
    drive(1, 0, 24'hFFFFFE, 24'h111111, 24'h222222, "R3");
    // R7: masked interrupt keeps line high while flag set
    setIrq(1'b0, "R7");
    drive(0, 1, 24'h0, 24'h0, 24'h0, "R6");
    // R2: other source ignored, counter untouched
    setMode(3'b011, 2'd0, 2'd1);
    drive(1, 0, 24'h0A0A0A, 24'h0, 24'h0, "R2");
    drive(1, 0, 24'h0B0B0B, 24'h0, 24'h0, "R2");
    setMode(3'b000, 2'd0, 2'd1);
    setIrq(1'b1, "R7");
    drive(1, 0, 24'h0C0C0C, 24'h0, 24'h0, "R2");
    drive(1, 0, 24'h0D0D0D, 24'h0, 24'h0, "R4");
    drive(1, 1, 24'h0E0E0E, 24'h0, 24'h0, "R4");
    // R4: divide by 4 and by 8
    setMode(3'b000, 2'd0, 2'd2);
    for (int i = 0; i < 9; i++)
      drive(1, (i % 3) == 0, 24'h100000 + 24'(i), 24'h0, 24'h0, "R4");
    setMode(3'b000, 2'd0, 2'd3);
    for (int i = 0; i < 17; i++)
      drive(1, 0, 24'h200000 + 24'(i), 24'h0, 24'h0, "R4");
    // R5: phase change restarts count mid-window
    drive(1, 1, 24'h300001, 24'h300002, 24'h0, "R4");
    setMode(3'b000, 2'd1, 2'd3);
    drive(1, 0, 24'h300003, 24'h300004, 24'h0, "R5");
    drive(1, 0, 24'h300005, 24'h300006, 24'h0, "R5");
    setMode(3'b000, 2'd1, 2'd1);
    drive(1, 0, 24'h300007, 24'h300008, 24'h0, "R5");
    drive(1, 0, 24'h300009, 24'h30000A, 24'h0, "R5");
    // R6: capture in the same cycle as a read keeps the flag
    drive(1, 1, 24'h0, 24'h40000B, 24'h0, "R6");
    drive(0, 1, 24'h0, 24'h0, 24'h0, "R6");
    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule